// File: doc/BRIEF.md
# ASN-Tagged Fully Associative Translation Buffer

This block is a small, fully associative store of page translations. Each slot holds a virtual page number tag, an 8-bit address space number, a global flag, a physical page number and a 10-bit attribute word. The attribute word carries per-mode read and write enables and two fault-on-access flags. A combinational lookup port takes a virtual page number and the current address space number. It returns a hit flag and the matching slot's page number and attributes in the same cycle. A slot matches when it is valid, its tag equals the requested page and it is either global or owned by the requesting address space.

Three recently hit slot indices sit in front of the array and are searched first, most recent first. Any insert or flush empties them. The block applies one command per cycle through `cmd_op`, and the command takes effect on the next clock edge. The commands are: insert at the round-robin replacement pointer, flush everything, flush the entries of every process (global ones survive), flush one address, and advance the pointer. The slot under the pointer is always visible on a read port.

The decode runs in these command states: IDLE (codes 0, 6 and 7), INSERT (1), FLUSH_ALL (2), FLUSH_PROC (3), FLUSH_ADDR (4) and ADVANCE (5). Each returns to IDLE on the next cycle unless a new code is presented.

Top module: `tlb_asn_cache`

## Requirements
- R1: `lk_hit` is 1 only while `lk_req` is 1 and some slot is valid, has a tag equal to `lk_vpn`, and is global or stores an address space number equal to `lk_asn`. On a hit, `lk_ppn` and `lk_attr` are that slot's contents.
- R2: Address space numbers are compared over all 8 bits, so a non-global slot whose number differs only in bit 7 does not match.
- R3: When several array slots match and none of the recent slots does, the lowest slot index supplies the result.
- R4: The three recent slots are searched before the array, most recent first. A lookup that is answered by the array with `lk_req` high records that slot index as most recent, and the oldest recorded index is dropped.
- R5: Any insert or flush command (codes 1 to 4) empties the recent slots, so later lookups fall back to array priority.
- R6: Insert (code 1) writes `cmd_vpn`, `cmd_asn`, `cmd_global`, `cmd_ppn` and `cmd_attr` into the slot at the pointer and marks it valid, overwriting any old content. It then advances the pointer, and the pointer wraps from the last slot to slot 0.
- R7: Flush-all (code 2) clears every valid flag and sets the pointer to 0.
- R8: Flush-process (code 3) invalidates every non-global slot and leaves global slots valid.
- R9: Flush-address (code 4) invalidates every valid slot whose tag equals `cmd_vpn` and that is global or holds `cmd_asn`. All other slots are untouched.
- R10: The read port always shows the slot at the pointer. The pointer moves only on insert, on flush-all (which sets it to 0) or on advance (code 5).
- R11: Attribute bits are kept unchanged: bits 3:0 are the read enables per mode, bits 7:4 the write enables per mode, bit 8 fault-on-read and bit 9 fault-on-write.
- R12: After reset no slot is valid and the pointer is 0. Codes 0, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_op | input | 3 | Command code for this cycle |
| cmd_vpn | input | VPN_W | Page number for insert or flush-address |
| cmd_asn | input | 8 | Address space number for insert or flush-address |
| cmd_global | input | 1 | Global flag for insert |
| cmd_ppn | input | PPN_W | Physical page number for insert |
| cmd_attr | input | 10 | Attribute word for insert |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_asn | input | 8 | Lookup address space number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Matching physical page number, 0 on miss |
| lk_attr | output | 10 | Matching attribute word, 0 on miss |
| rd_valid | output | 1 | Valid flag of the slot at the pointer |
| rd_vpn | output | VPN_W | Tag of the slot at the pointer |
| rd_asn | output | 8 | Address space number of the slot at the pointer |
| rd_global | output | 1 | Global flag of the slot at the pointer |
| rd_ppn | output | PPN_W | Physical page number of the slot at the pointer |
| rd_attr | output | 10 | Attribute word of the slot at the pointer |

## Verification
The bench builds the block with four slots, 6-bit page numbers and 6-bit physical page numbers. Every possible page number can then be swept against several address space values after each phase. Four slots also make pointer wraparound and overwrite occur after a handful of inserts. With three recent slots against four array slots, the case where a recent slot overrides array priority can be reached and is compared against an arithmetic model every cycle.

// File: rtl/tlb_asn_pkg.sv
package tlb_asn_pkg;
    localparam int ASN_W  = 8;
    localparam int MODE_N = 4;
    localparam int ATTR_W = 2 * MODE_N + 2;

    typedef enum logic [2:0] {
        OP_IDLE       = 3'd0,
        OP_INSERT     = 3'd1,
        OP_FLUSH_ALL  = 3'd2,
        OP_FLUSH_PROC = 3'd3,
        OP_FLUSH_ADDR = 3'd4,
        OP_ADVANCE    = 3'd5
    } tlb_op_e;
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
    import tlb_asn_pkg::*;
#(
    parameter int VPN_W = 30
) (
    input  logic             ent_valid,
    input  logic [VPN_W-1:0] ent_tag,
    input  logic [ASN_W-1:0] ent_asn,
    input  logic             ent_global,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [ASN_W-1:0] req_asn,
    output logic             hit
);
    always_comb begin
        hit = ent_valid && (ent_tag == req_vpn) && (ent_global || (ent_asn == req_asn));
    end
endmodule

// File: rtl/tlb_lowest_first.sv
module tlb_lowest_first #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

    // R3: the chosen bit is set and no lower bit is set
    always_comb begin
        if (found_o) begin
            assert_enc_lowest_R3: assert (req_i[idx_o] &&
                ((req_i & ((N'(1) << idx_o) - N'(1))) == '0));
        end
    end
endmodule

// File: rtl/tlb_recent_buf.sv
module tlb_recent_buf #(
    parameter int DEPTH = 3,
    parameter int IDX_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic                        push_i,
    input  logic [IDX_W-1:0]            push_idx_i,
    output logic [DEPTH-1:0][IDX_W-1:0] slot_idx_o,
    output logic [DEPTH-1:0]            slot_vld_o
);
    logic [DEPTH-1:0][IDX_W-1:0] idx_q;
    logic [DEPTH-1:0]            vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            vld_q <= '0;
        end else if (clear_i) begin
            vld_q <= '0;
        end else if (push_i) begin
            idx_q[0] <= push_idx_i;
            vld_q[0] <= 1'b1;
            for (int s = 1; s < DEPTH; s++) begin
                idx_q[s] <= idx_q[s-1];
                vld_q[s] <= vld_q[s-1];
            end
        end
    end

    assign slot_idx_o = idx_q;
    assign slot_vld_o = vld_q;

    assert_recent_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (slot_vld_o == '0));

    assert_recent_front_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clear_i) |=> (slot_vld_o[0] && slot_idx_o[0] == $past(push_idx_i)));
endmodule

// File: rtl/tlb_asn_cache.sv
module tlb_asn_cache
    import tlb_asn_pkg::*;
#(
    parameter int ENTRIES  = 16,
    parameter int VPN_W    = 30,
    parameter int PPN_W    = 28,
    parameter int RECENT_N = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cmd_op,
    input  logic [VPN_W-1:0]  cmd_vpn,
    input  logic [ASN_W-1:0]  cmd_asn,
    input  logic              cmd_global,
    input  logic [PPN_W-1:0]  cmd_ppn,
    input  logic [ATTR_W-1:0] cmd_attr,
    input  logic              lk_req,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              rd_valid,
    output logic [VPN_W-1:0]  rd_vpn,
    output logic [ASN_W-1:0]  rd_asn,
    output logic              rd_global,
    output logic [PPN_W-1:0]  rd_ppn,
    output logic [ATTR_W-1:0] rd_attr
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int REC_W = (RECENT_N > 1) ? $clog2(RECENT_N) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    // slot storage
    logic [ENTRIES-1:0] v_q;
    logic [ENTRIES-1:0] g_q;
    logic [VPN_W-1:0]   tag_q  [ENTRIES];
    logic [ASN_W-1:0]   asn_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic [ATTR_W-1:0]  attr_q [ENTRIES];
    logic [IDX_W-1:0]   ptr_q;
    logic [IDX_W-1:0]   ptr_inc;

    // command decode
    tlb_op_e op_state;
    logic do_insert, do_fall, do_fproc, do_faddr, do_adv;

    always_comb begin
        op_state  = tlb_op_e'(cmd_op);
        do_insert = 1'b0;
        do_fall   = 1'b0;
        do_fproc  = 1'b0;
        do_faddr  = 1'b0;
        do_adv    = 1'b0;
        unique case (op_state)
            OP_INSERT:     do_insert = 1'b1;
            OP_FLUSH_ALL:  do_fall   = 1'b1;
            OP_FLUSH_PROC: do_fproc  = 1'b1;
            OP_FLUSH_ADDR: do_faddr  = 1'b1;
            OP_ADVANCE:    do_adv    = 1'b1;
            default:       ;
        endcase
    end

    // per-slot match columns: one for lookup, one for flush-address
    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fa_match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        tlb_entry_match #(.VPN_W(VPN_W)) u_lk (
            .ent_valid (v_q[i]),
            .ent_tag   (tag_q[i]),
            .ent_asn   (asn_q[i]),
            .ent_global(g_q[i]),
            .req_vpn   (lk_vpn),
            .req_asn   (lk_asn),
            .hit       (lk_match[i])
        );
        tlb_entry_match #(.VPN_W(VPN_W)) u_fa (
            .ent_valid (v_q[i]),
            .ent_tag   (tag_q[i]),
            .ent_asn   (asn_q[i]),
            .ent_global(g_q[i]),
            .req_vpn   (cmd_vpn),
            .req_asn   (cmd_asn),
            .hit       (fa_match[i])
        );
    end

    // array priority
    logic             arr_found;
    logic [IDX_W-1:0] arr_idx;

    tlb_lowest_first #(.N(ENTRIES), .IDX_W(IDX_W)) u_arr_enc (
        .req_i  (lk_match),
        .found_o(arr_found),
        .idx_o  (arr_idx)
    );

    // recent-hit slots
    logic [RECENT_N-1:0][IDX_W-1:0] rec_idx;
    logic [RECENT_N-1:0]            rec_vld;
    logic [RECENT_N-1:0]            rec_match;
    logic                           rec_found;
    logic [REC_W-1:0]               rec_sel;
    logic                           rec_clear;
    logic                           rec_push;

    for (genvar s = 0; s < RECENT_N; s++) begin : g_recent
        logic [IDX_W-1:0] ri;
        assign ri = rec_idx[s];
        tlb_entry_match #(.VPN_W(VPN_W)) u_rm (
            .ent_valid (rec_vld[s] & v_q[ri]),
            .ent_tag   (tag_q[ri]),
            .ent_asn   (asn_q[ri]),
            .ent_global(g_q[ri]),
            .req_vpn   (lk_vpn),
            .req_asn   (lk_asn),
            .hit       (rec_match[s])
        );
    end

    tlb_lowest_first #(.N(RECENT_N), .IDX_W(REC_W)) u_rec_enc (
        .req_i  (rec_match),
        .found_o(rec_found),
        .idx_o  (rec_sel)
    );

    assign rec_clear = do_insert | do_fall | do_fproc | do_faddr;
    assign rec_push  = lk_req & ~rec_found & arr_found;

    tlb_recent_buf #(.DEPTH(RECENT_N), .IDX_W(IDX_W)) u_recent (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (rec_clear),
        .push_i    (rec_push),
        .push_idx_i(arr_idx),
        .slot_idx_o(rec_idx),
        .slot_vld_o(rec_vld)
    );

    // lookup outputs
    logic [IDX_W-1:0] sel_idx;

    always_comb begin
        sel_idx = rec_found ? rec_idx[rec_sel] : arr_idx;
        lk_hit  = lk_req & (rec_found | arr_found);
        lk_ppn  = lk_hit ? ppn_q[sel_idx]  : '0;
        lk_attr = lk_hit ? attr_q[sel_idx] : '0;
    end

    // read port
    always_comb begin
        rd_valid  = v_q[ptr_q];
        rd_vpn    = tag_q[ptr_q];
        rd_asn    = asn_q[ptr_q];
        rd_global = g_q[ptr_q];
        rd_ppn    = ppn_q[ptr_q];
        rd_attr   = attr_q[ptr_q];
    end

    assign ptr_inc = (ptr_q == LAST_IDX) ? '0 : ptr_q + IDX_W'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q   <= '0;
            g_q   <= '0;
            ptr_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]  <= '0;
                asn_q[i]  <= '0;
                ppn_q[i]  <= '0;
                attr_q[i] <= '0;
            end
        end else begin
            unique case (op_state)
                OP_FLUSH_ALL: begin
                    v_q   <= '0;
                    ptr_q <= '0;
                end
                OP_FLUSH_PROC: v_q <= v_q & g_q;
                OP_FLUSH_ADDR: v_q <= v_q & ~fa_match;
                OP_INSERT: begin
                    v_q[ptr_q]    <= 1'b1;
                    g_q[ptr_q]    <= cmd_global;
                    tag_q[ptr_q]  <= cmd_vpn;
                    asn_q[ptr_q]  <= cmd_asn;
                    ppn_q[ptr_q]  <= cmd_ppn;
                    attr_q[ptr_q] <= cmd_attr;
                    ptr_q         <= ptr_inc;
                end
                OP_ADVANCE: ptr_q <= ptr_inc;
                default: ;
            endcase
        end
    end

    // assertions
    assert_hit_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (v_q[sel_idx] && tag_q[sel_idx] == lk_vpn &&
                    (g_q[sel_idx] || asn_q[sel_idx] == lk_asn)));

    assert_insert_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_insert |=> (v_q[$past(ptr_q)] && tag_q[$past(ptr_q)] == $past(cmd_vpn)));

    assert_flush_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        do_fall |=> (v_q == '0 && ptr_q == '0));

    assert_flush_proc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        do_fproc |=> (((v_q & ~g_q) == '0) && ((v_q & g_q) == $past(v_q & g_q))));

    assert_flush_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        do_faddr |=> ((v_q & $past(fa_match)) == '0));

    assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_insert || do_adv || do_fall) |=> $stable(ptr_q));
endmodule

// File: tb/tlb_asn_cache_tb.sv
module tlb_asn_cache_tb_top;
    localparam int NE  = 4;
    localparam int VW  = 6;
    localparam int PW  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [VW-1:0] cmd_vpn = '0;
    logic [7:0]    cmd_asn = '0;
    logic          cmd_global = 1'b0;
    logic [PW-1:0] cmd_ppn = '0;
    logic [9:0]    cmd_attr = '0;
    logic          lk_req = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [7:0]    lk_asn = '0;
    logic          lk_hit;
    logic [PW-1:0] lk_ppn;
    logic [9:0]    lk_attr;
    logic          rd_valid;
    logic [VW-1:0] rd_vpn;
    logic [7:0]    rd_asn;
    logic          rd_global;
    logic [PW-1:0] rd_ppn;
    logic [9:0]    rd_attr;

    always #4 clk = ~clk;

    tlb_asn_cache #(.ENTRIES(NE), .VPN_W(VW), .PPN_W(PW), .RECENT_N(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_vpn(cmd_vpn),
        .cmd_asn(cmd_asn), .cmd_global(cmd_global), .cmd_ppn(cmd_ppn),
        .cmd_attr(cmd_attr), .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_attr(lk_attr),
        .rd_valid(rd_valid), .rd_vpn(rd_vpn), .rd_asn(rd_asn),
        .rd_global(rd_global), .rd_ppn(rd_ppn), .rd_attr(rd_attr)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model
    bit m_v [NE];
    bit m_g [NE];
    int m_vpn [NE];
    int m_asn [NE];
    int m_ppn [NE];
    int m_attr [NE];
    int m_ptr = 0;
    int m_rec [3];
    bit m_recv [3];

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    function automatic bit m_slot_hit(input int i, input int vpn, input int asn);
        return m_v[i] && (m_vpn[i] == vpn) && (m_g[i] || (m_asn[i] == asn));
    endfunction

    task automatic m_look(input int vpn, input int asn, output bit hit, output int idx,
                          output bit from_rec);
        hit = 0; idx = 0; from_rec = 0;
        for (int s = 0; s < 3; s++) begin
            if (!hit && m_recv[s] && m_slot_hit(m_rec[s], vpn, asn)) begin
                hit = 1; idx = m_rec[s]; from_rec = 1;
            end
        end
        for (int i = 0; i < NE; i++) begin
            if (!hit && m_slot_hit(i, vpn, asn)) begin
                hit = 1; idx = i;
            end
        end
    endtask

    task automatic cyc(input string rq, input int op, input int vpn, input int asn,
                       input bit glb, input int ppn, input int attr,
                       input bit lreq, input int lvpn, input int lasn);
        bit eh, fr;
        int ei;
        cmd_op = 3'(op); cmd_vpn = VW'(vpn); cmd_asn = 8'(asn); cmd_global = glb;
        cmd_ppn = PW'(ppn); cmd_attr = 10'(attr);
        lk_req = lreq; lk_vpn = VW'(lvpn); lk_asn = 8'(lasn);
        #1;
        m_look(lvpn, lasn, eh, ei, fr);
        if (!lreq) eh = 0;
        chk(rq, "lk_hit", int'(lk_hit), int'(eh));
        if (eh) begin
            chk(rq, "lk_ppn", int'(lk_ppn), m_ppn[ei]);
            chk(rq, "lk_attr", int'(lk_attr), m_attr[ei]);
        end
        chk(rq, "rd_valid", int'(rd_valid), int'(m_v[m_ptr]));
        chk(rq, "rd_vpn", int'(rd_vpn), m_vpn[m_ptr]);
        chk(rq, "rd_asn", int'(rd_asn), m_asn[m_ptr]);
        chk(rq, "rd_global", int'(rd_global), int'(m_g[m_ptr]));
        chk(rq, "rd_ppn", int'(rd_ppn), m_ppn[m_ptr]);
        chk(rq, "rd_attr", int'(rd_attr), m_attr[m_ptr]);
        @(posedge clk);
        if (op >= 1 && op <= 4) begin
            for (int s = 0; s < 3; s++) m_recv[s] = 0;
        end else if (eh && !fr) begin
            m_rec[2] = m_rec[1]; m_recv[2] = m_recv[1];
            m_rec[1] = m_rec[0]; m_recv[1] = m_recv[0];
            m_rec[0] = ei;       m_recv[0] = 1;
        end
        case (op)
            1: begin
                m_v[m_ptr] = 1; m_vpn[m_ptr] = vpn; m_asn[m_ptr] = asn; m_g[m_ptr] = glb;
                m_ppn[m_ptr] = ppn; m_attr[m_ptr] = attr; m_ptr = (m_ptr + 1) % NE;
            end
            2: begin
                for (int i = 0; i < NE; i++) m_v[i] = 0;
                m_ptr = 0;
            end
            3: for (int i = 0; i < NE; i++) m_v[i] = m_v[i] & m_g[i];
            4: for (int i = 0; i < NE; i++) if (m_slot_hit(i, vpn, asn)) m_v[i] = 0;
            5: m_ptr = (m_ptr + 1) % NE;
            default: ;
        endcase
        #1;
    endtask

    task automatic look(input string rq, input int lvpn, input int lasn);
        cyc(rq, 0, 0, 0, 0, 0, 0, 1, lvpn, lasn);
    endtask

    task automatic sweep(input string rq);
        int al [5] = '{0, 1, 8'h80, 8'h81, 8'h7f};
        for (int v = 0; v < 64; v++)
            for (int a = 0; a < 5; a++)
                look(rq, v, al[a]);
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_v[i] = 0; m_g[i] = 0; m_vpn[i] = 0; m_asn[i] = 0; m_ppn[i] = 0; m_attr[i] = 0;
        end
        for (int s = 0; s < 3; s++) begin m_rec[s] = 0; m_recv[s] = 0; end
        #22 rst_n = 1'b1;

        // R12: reset state
        look("R12", 0, 0);
        chk("R12", "rd_valid after reset", int'(rd_valid), 0);

        // R6: fill all four slots, pointer wraps
        cyc("R6", 1, 5, 1, 0, 10, 10'h0F1, 0, 0, 0);
        cyc("R6", 1, 5, 7, 1, 11, 10'h2A5, 0, 0, 0);
        cyc("R6", 1, 9, 8'h80, 0, 12, 10'h15A, 0, 0, 0);
        cyc("R6", 1, 9, 8'h00, 0, 13, 10'h3FF, 0, 0, 0);
        chk("R6", "pointer wrapped to slot 0 tag", int'(rd_vpn), 5);

        // R3: two matches, lowest slot wins
        look("R3", 5, 1);
        // R2: full 8-bit ASN compare
        look("R2", 9, 8'h80);
        look("R2", 9, 8'h00);
        look("R2", 9, 8'h01);
        // R1: no request, no hit
        cyc("R1", 0, 0, 0, 0, 0, 0, 0, 5, 1);

        // R4: global slot recorded, then overrides array priority
        look("R4", 5, 2);
        look("R4", 5, 1);
        chk("R4", "recent slot answers", int'(lk_ppn), 11);

        // R5: a flush of an absent address empties recent slots
        cyc("R5", 4, 63, 0, 0, 0, 0, 0, 0, 0);
        look("R5", 5, 1);
        chk("R5", "array priority restored", int'(lk_ppn), 10);

        // R11: attribute layout round trip
        look("R11", 9, 0);
        chk("R11", "read enables", int'(lk_attr[3:0]), 4'hF);
        chk("R11", "fault-on-write", int'(lk_attr[9]), 1);

        sweep("R1");

        // R10 / R12: idle codes keep pointer, advance moves it
        cyc("R12", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R12", 6, 5, 1, 0, 0, 0, 0, 0, 0);
        cyc("R12", 7, 5, 1, 0, 0, 0, 0, 0, 0);
        cyc("R10", 5, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10", "advanced to slot 1", int'(rd_ppn), 11);

        // R6: overwrite slot 1 with a new global page
        cyc("R6", 1, 20, 3, 1, 33, 10'h101, 0, 0, 0);
        look("R6", 5, 2);
        look("R6", 20, 8'h44);
        sweep("R6");

        // R9: flush-address by ASN and for a global slot
        cyc("R9", 4, 9, 8'h80, 0, 0, 0, 0, 0, 0);
        look("R9", 9, 8'h80);
        look("R9", 9, 8'h00);
        cyc("R9", 4, 20, 8'h33, 0, 0, 0, 0, 0, 0);
        look("R9", 20, 3);
        sweep("R9");

        // R8: flush-process keeps globals
        cyc("R8", 1, 30, 5, 1, 40, 10'h0C3, 0, 0, 0);
        cyc("R8", 1, 31, 5, 0, 41, 10'h0C4, 0, 0, 0);
        cyc("R8", 3, 0, 0, 0, 0, 0, 0, 0, 0);
        look("R8", 30, 9);
        look("R8", 31, 5);
        sweep("R8");

        // R7: flush-all from a nonzero pointer
        cyc("R7", 5, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R7", 2, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R7", 1, 44, 2, 0, 50, 10'h011, 0, 0, 0);
        look("R7", 44, 2);
        sweep("R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule